// File: doc/BRIEF.md
# Write-Through Store Buffer with Load Forwarding

This block sits between a write-through cache and the next memory level. Each store the cache controller issues is parked as an address and data pair in a small circular queue. The processor can then keep running while the queued words are sent to memory in the background, oldest first, over a valid/ready handshake. When every slot is taken, the store port withholds its ready signal until a slot frees up.

A load lookup port compares a load address against every pending entry at once. If several entries hold the same address, it returns the most recently queued word. A load therefore never reads an old value from memory while a newer store is still waiting in the queue, and nothing has to be drained before the read. The result is a hit flag plus data, formed combinationally in the cycle of the lookup. A slot that drains in the current cycle still takes part in that cycle's lookup. A store accepted in the same cycle becomes visible to lookups from the next cycle on.

Top module: `wbuf_forward`

## Requirements
- R1: During and right after reset the buffer reports empty=1, full=0, mem_valid=0 and ld_hit=0.
- R2: While the buffer is not full, st_ready is 1, and a store presented with st_valid=1 is queued at that clock edge.
- R3: While the buffer is full and no drain happens in the cycle, st_ready is 0 and a presented store is dropped: a later lookup of its address misses, unless some other queued store has that address.
- R4: mem_valid is 1 whenever the buffer is not empty. mem_addr and mem_data show the oldest queued entry, and entries leave in the order they arrived.
- R5: Exactly one entry leaves per clock edge at which mem_valid=1 and mem_ready=1. While mem_ready=0, mem_addr and mem_data stay unchanged.
- R6: ld_hit is 1 in the same cycle exactly when some pending entry's address equals ld_addr, and ld_data then carries that entry's data. Otherwise ld_hit is 0.
- R7: When several pending entries match ld_addr, ld_data comes from the most recently queued of them.
- R8: When the buffer is full and the oldest entry drains in the same cycle, st_ready is 1 and the new store is queued, so full stays 1 after the edge.
- R9: An entry draining in the current cycle is still returned by that cycle's lookup. A store accepted in a cycle is not seen by that cycle's lookup but is seen from the next cycle on.
- R10: The buffer holds DEPTH entries (default 4). full becomes 1 after DEPTH stores with no drain, and full and empty are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store write data |
| st_ready | output | 1 | Store accepted this cycle; 0 stalls the requester |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | A pending entry matches ld_addr |
| ld_data | output | DW | Data of the youngest matching entry |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_addr | output | AW | Address of the oldest entry |
| mem_data | output | DW | Data of the oldest entry |
| mem_ready | input | 1 | Memory takes the offered entry at this edge |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
Three timings apply:
- ld_hit, ld_data and st_ready are combinational and are due in the same cycle as the inputs that cause them.
- full, empty, mem_valid, mem_addr and mem_data change at the first rising edge after an accepted store or drain.
- The effect of a store on lookups also appears at that edge.

The bench drives every input just after a falling edge and samples about 1 ns later, still before the next rising edge. A same-cycle result is therefore read in the cycle of its stimulus, and a registered result is read in the step that follows the edge. The same-cycle store-and-lookup case and the drain-while-full case are checked on both sides of that edge.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  parameter int unsigned WB_DEPTH_DEF = 4;
  parameter int unsigned WB_AW_DEF    = 8;
  parameter int unsigned WB_DW_DEF    = 16;
endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl #(
  parameter int unsigned DEPTH = wbuf_pkg::WB_DEPTH_DEF,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic             mem_ready,
  output logic             st_ready,
  output logic             mem_valid,
  output logic             full,
  output logic             empty,
  output logic             push,
  output logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [DEPTH-1:0] valid
);
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [DEPTH-1:0] valid_q, valid_d;

  always_comb begin
    empty     = ~|valid_q;
    full      = &valid_q;
    mem_valid = !empty;
    pop       = mem_valid && mem_ready;
    st_ready  = !full || pop;
    push      = st_valid && st_ready;
  end

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    valid_d = valid_q;
    if (pop) begin
      valid_d[head_q] = 1'b0;
      head_d = (head_q == PTR_W'(DEPTH-1)) ? '0 : head_q + 1'b1;
    end
    if (push) begin
      valid_d[tail_q] = 1'b1;
      tail_d = (tail_q == PTR_W'(DEPTH-1)) ? '0 : tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      valid_q <= '0;
    end else if (push || pop) begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      valid_q <= valid_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign valid = valid_q;

  // A full buffer without a drain must not take a store
  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !mem_ready) |=> ($stable(tail_q) && full));

  // Drain and store in one cycle while full keeps the buffer full
  assert_accept_on_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && mem_ready && st_valid) |=> full);
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int unsigned DEPTH = wbuf_pkg::WB_DEPTH_DEF,
  parameter int unsigned AW    = wbuf_pkg::WB_AW_DEF,
  parameter int unsigned DW    = wbuf_pkg::WB_DW_DEF,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             push,
  input  logic [PTR_W-1:0] tail,
  input  logic [PTR_W-1:0] head,
  input  logic [AW-1:0]    st_addr,
  input  logic [DW-1:0]    st_data,
  output logic [AW-1:0]    addr_q [DEPTH],
  output logic [DW-1:0]    data_q [DEPTH],
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_data
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_en;
    assign wr_en = push && (tail == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        addr_q[i] <= st_addr;
        data_q[i] <= st_data;
      end
    end
  end

  assign mem_addr = addr_q[head];
  assign mem_data = data_q[head];
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int unsigned DEPTH = wbuf_pkg::WB_DEPTH_DEF,
  parameter int unsigned AW    = wbuf_pkg::WB_AW_DEF,
  parameter int unsigned DW    = wbuf_pkg::WB_DW_DEF,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] valid,
  input  logic [PTR_W-1:0] head,
  input  logic [AW-1:0]    addr_q [DEPTH],
  input  logic [DW-1:0]    data_q [DEPTH],
  input  logic [AW-1:0]    ld_addr,
  output logic             ld_hit,
  output logic [DW-1:0]    ld_data
);
  logic [PTR_W-1:0] slot_of_age [DEPTH];

  // slot holding the entry of age k (0 = oldest)
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PTR_W:0] sum;
    assign sum = {1'b0, head} + (PTR_W+1)'(k);
    assign slot_of_age[k] = (sum >= (PTR_W+1)'(DEPTH)) ?
                            PTR_W'(sum - (PTR_W+1)'(DEPTH)) : sum[PTR_W-1:0];
  end

  // walk from oldest to youngest; the last match overrides
  always_comb begin
    ld_hit  = 1'b0;
    ld_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (valid[slot_of_age[k]] && (addr_q[slot_of_age[k]] == ld_addr)) begin
        ld_hit  = 1'b1;
        ld_data = data_q[slot_of_age[k]];
      end
    end
  end
endmodule

// File: rtl/wbuf_forward.sv
module wbuf_forward #(
  parameter int unsigned DEPTH = wbuf_pkg::WB_DEPTH_DEF,
  parameter int unsigned AW    = wbuf_pkg::WB_AW_DEF,
  parameter int unsigned DW    = wbuf_pkg::WB_DW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready,
  output logic          full,
  output logic          empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             push, pop;
  logic [PTR_W-1:0] head, tail;
  logic [DEPTH-1:0] valid;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];

  wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .mem_ready(mem_ready),
    .st_ready(st_ready), .mem_valid(mem_valid), .full(full), .empty(empty),
    .push(push), .pop(pop), .head(head), .tail(tail), .valid(valid)
  );

  wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .push(push), .tail(tail), .head(head),
    .st_addr(st_addr), .st_data(st_data), .addr_q(addr_q), .data_q(data_q),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  wbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .valid(valid), .head(head), .addr_q(addr_q), .data_q(data_q),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data)
  );

  // Offered drain entry holds while memory back-pressures
  assert_drain_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // A forwarded hit needs a pending entry
  assert_hit_needs_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> !empty);

  // Status flags are exclusive
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // Every drain handshake takes an entry out (push may refill one)
  assert_one_per_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && $countones(valid) == 1) |=> empty);
endmodule

// File: tb/tb_wbuf_forward.sv
`timescale 1ns/1ps
module tb_wbuf_forward;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, mem_ready;
  logic [7:0]  st_addr, ld_addr;
  logic [15:0] st_data;
  logic        st_ready, ld_hit, mem_valid, full, empty;
  logic [15:0] ld_data, mem_data;
  logic [7:0]  mem_addr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wbuf_forward dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_ready(st_ready), .ld_addr(ld_addr),
    .ld_hit(ld_hit), .ld_data(ld_data), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .full(full), .empty(empty)
  );

  // {op[1:0], addr[7:0], data[15:0], hit}; op 0=store 1=lookup 2=drain
  localparam int NV = 11;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 8'h10, 16'hA1A1, 1'b0},
    {2'd0, 8'h20, 16'hB2B2, 1'b0},
    {2'd0, 8'h10, 16'hC3C3, 1'b0},
    {2'd1, 8'h10, 16'hC3C3, 1'b1},
    {2'd1, 8'h20, 16'hB2B2, 1'b1},
    {2'd1, 8'h30, 16'h0000, 1'b0},
    {2'd2, 8'h10, 16'hA1A1, 1'b0},
    {2'd1, 8'h10, 16'hC3C3, 1'b1},
    {2'd2, 8'h20, 16'hB2B2, 1'b0},
    {2'd2, 8'h10, 16'hC3C3, 1'b0},
    {2'd1, 8'h10, 16'h0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic sv, input logic [7:0] sa, input logic [15:0] sd,
                       input logic [7:0] la, input logic mr);
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; ld_addr = la; mem_ready = mr;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    st_valid = 0; st_addr = 0; st_data = 0; ld_addr = 0; mem_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(0, 8'h0, 16'h0, 8'h0, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 ld_hit", ld_hit, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [7:0] a; logic [15:0] d; logic h;
      {op, a, d, h} = VEC[i];
      case (op)
        2'd0: begin
          drive(1, a, d, 8'hFF, 0);
          chk("R2 st_ready", st_ready, 1);
        end
        2'd1: begin
          drive(0, 8'h0, 16'h0, a, 0);
          chk("R6_R7 hit", ld_hit, h);
          if (h) chk("R6_R7 data", ld_data, d);
        end
        default: begin
          drive(0, 8'h0, 16'h0, 8'hFF, 1);
          chk("R4 mem_valid", mem_valid, 1);
          chk("R4 mem_addr", mem_addr, a);
          chk("R4 mem_data", mem_data, d);
        end
      endcase
    end
    drive(0, 8'h0, 16'h0, 8'hFF, 0);
    chk("R4 empty after drain", empty, 1);

    // fill to capacity
    for (int i = 0; i < 4; i++) drive(1, 8'h80 + 8'(i), 16'h1000 + 16'(i), 8'hFF, 0);
    drive(1, 8'h77, 16'h7777, 8'h77, 0);
    chk("R10 full", full, 1);
    chk("R3 stalled", st_ready, 0);
    drive(0, 8'h0, 16'h0, 8'h77, 0);
    chk("R3 dropped store", ld_hit, 0);
    chk("R5 held addr", mem_addr, 8'h80);
    chk("R5 held data", mem_data, 16'h1000);
    drive(1, 8'h55, 16'h5555, 8'hFF, 1);
    chk("R8 ready while draining", st_ready, 1);
    drive(0, 8'h0, 16'h0, 8'h55, 0);
    chk("R8 still full", full, 1);
    chk("R8 new entry", ld_data, 16'h5555);
    chk("R5 next oldest", mem_addr, 8'h81);
    for (int i = 1; i < 4; i++) begin
      drive(0, 8'h0, 16'h0, 8'hFF, 1);
      chk("R4 order addr", mem_addr, 8'h80 + 8'(i));
      chk("R4 order data", mem_data, 16'h1000 + 16'(i));
    end
    drive(0, 8'h0, 16'h0, 8'hFF, 1);
    chk("R4 last addr", mem_addr, 8'h55);
    drive(0, 8'h0, 16'h0, 8'hFF, 0);
    chk("R10 empty", empty, 1);
    chk("R10 not full", full, 0);

    // same-cycle visibility
    drive(1, 8'h40, 16'h1111, 8'hFF, 0);
    drive(1, 8'h40, 16'h2222, 8'h40, 1);
    chk("R9 draining hit", ld_hit, 1);
    chk("R9 draining data", ld_data, 16'h1111);
    drive(0, 8'h0, 16'h0, 8'h40, 0);
    chk("R9 new store seen", ld_data, 16'h2222);
    chk("R9 not empty", empty, 0);
    drive(0, 8'h0, 16'h0, 8'h40, 1);
    drive(0, 8'h0, 16'h0, 8'h40, 0);
    chk("R5 one per handshake", empty, 1);
    chk("R6 miss when empty", ld_hit, 0);
    finish_run();
  end
endmodule